// File: doc/BRIEF.md
# Evolvable Image Filter Fitness Unit

This block scores one candidate image filter for a hardware search loop. The candidate is a feed-forward chain of small 8-bit processing elements. A configuration word chooses, for each element, two operand sources and one of eight functions. The element chain reads the nine pixels of a 3x3 window cut from a noisy image. A separate output gene names the node whose value is the filtered pixel.

Window and reference pixel pairs arrive as a stream, one pair per qualified beat, in raster order over a K x K image. For every position whose window lies fully inside the image, the unit adds the absolute difference between the filtered pixel and the clean reference pixel to a running total. Border positions are skipped. A lower total means a better filter. When the last interior position has been added, the unit raises a one-cycle done flag next to the final total. A start pulse clears the unit for the next candidate.

Top module: `evo_filter_fitness`

## Requirements
- R1: Element function codes are 0 OR, 1 AND, 2 XOR, 3 addition, 4 saturating addition, 5 average, 6 maximum and 7 minimum, each applied bitwise or numerically to two 8-bit operands.
- R2: Addition keeps the low 8 bits of the sum. Saturating addition returns 255 whenever the true sum exceeds 255. Average returns the 9-bit sum shifted right by one, so no carry is lost.
- R3: Node numbers 0..8 are the window pixels in row-major order, where pixel i sits at win_pix[8i+7:8i]. Node 9+e is element e. Element e's gene sits at cfg_genes[13e+12:13e] with operand A in bits 4:0, operand B in bits 9:5 and the function in bits 12:10. An operand number that is not below 9+e reads pixel 0.
- R4: The output gene at cfg_genes[108:104] picks the filter result node. A value of 17 or more selects pixel 0.
- R5: Each beat with in_valid high and start low is one raster position. The row advances after K columns. Positions in row 0, row K-1, column 0 or column K-1 add nothing to the total.
- R6: fitness is the sum of |filtered - reference| over the interior positions. Its width holds (K-2)^2 x 255 without overflow, which is 22 bits for K = 128.
- R7: done is high for exactly one cycle, two clock edges after the edge that accepts the beat at position (K-2, K-2). fitness already holds the final total in that cycle.
- R8: start clears the total, the raster position and any beats in flight, and forces done low. A beat offered in the same cycle as start is discarded.
- R9: After reset, fitness is 0 and done is low.
- R10: While in_valid is low, the total and the position do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear the unit for a new candidate |
| in_valid | input | 1 | Qualifies win_pix and ref_pix |
| win_pix | input | 72 | Nine window pixels, row-major |
| ref_pix | input | 8 | Clean reference pixel for the window centre |
| cfg_genes | input | 109 | Element genes followed by the output gene |
| fitness | output | ACC_W | Running total of absolute differences |
| done | output | 1 | One-cycle pulse when the total is final |

## Verification
The bench checks each function with operands chosen so that addition wraps (195+90 gives 29), saturating addition clamps, and the average keeps its carry. A design that dropped the ninth sum bit would report 14 instead of 142 for the average. Directed configurations point operands at the element itself and point the output gene beyond the last node. A design without the pixel-0 fallback would read a later or undefined node and give a different total. Random configurations, frames with gaps in in_valid, and a start pulse in the middle of a frame check that border positions are skipped and that in-flight beats are dropped. A full 128 x 128 frame of worst-case pixels reaches 4048380 and would wrap on a 21-bit accumulator.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int WIN_TAPS = 9;
  localparam int FN_W     = 3;

  typedef enum logic [FN_W-1:0] {
    FN_OR     = 3'd0,
    FN_AND    = 3'd1,
    FN_XOR    = 3'd2,
    FN_ADD    = 3'd3,
    FN_ADDSAT = 3'd4,
    FN_AVG    = 3'd5,
    FN_MAX    = 3'd6,
    FN_MIN    = 3'd7
  } fe_func_e;
endpackage

// File: rtl/fe_cell.sv
module fe_cell
  import fe_pkg::*;
#(
  parameter int W    = 8,
  parameter int NSRC = 9,
  parameter int IW   = 5
) (
  input  logic [NSRC*W-1:0] srcs,
  input  logic [IW-1:0]     sel_a,
  input  logic [IW-1:0]     sel_b,
  input  logic [FN_W-1:0]   func,
  output logic [W-1:0]      y
);
  logic [W-1:0] opa, opb;
  logic [W:0]   sum;

  // operands that do not refer to an earlier node fall back to pixel 0
  always_comb begin
    opa = srcs[W-1:0];
    opb = srcs[W-1:0];
    if (int'(sel_a) < NSRC) opa = srcs[sel_a*W +: W];
    if (int'(sel_b) < NSRC) opb = srcs[sel_b*W +: W];
  end

  assign sum = {1'b0, opa} + {1'b0, opb};

  always_comb begin
    case (fe_func_e'(func))
      FN_OR:     y = opa | opb;
      FN_AND:    y = opa & opb;
      FN_XOR:    y = opa ^ opb;
      FN_ADD:    y = sum[W-1:0];
      FN_ADDSAT: y = sum[W] ? {W{1'b1}} : sum[W-1:0];
      FN_AVG:    y = sum[W:1];
      FN_MAX:    y = (opa > opb) ? opa : opb;
      default:   y = (opa < opb) ? opa : opb;
    endcase
  end
endmodule

// File: rtl/fe_array.sv
module fe_array
  import fe_pkg::*;
#(
  parameter int W      = 8,
  parameter int N_ELEM = 8,
  parameter int IW     = 5,
  localparam int NODES = WIN_TAPS + N_ELEM,
  localparam int GW    = 2*IW + FN_W,
  localparam int CFG_W = N_ELEM*GW + IW
) (
  input  logic [WIN_TAPS*W-1:0] win,
  input  logic [CFG_W-1:0]      cfg,
  output logic [W-1:0]          y
);
  logic [NODES*W-1:0] nodes;
  logic [IW-1:0]      out_sel;

  assign nodes[WIN_TAPS*W-1:0] = win;

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    fe_cell #(.W(W), .NSRC(WIN_TAPS+e), .IW(IW)) u_cell (
      .srcs  (nodes[(WIN_TAPS+e)*W-1:0]),
      .sel_a (cfg[e*GW +: IW]),
      .sel_b (cfg[e*GW+IW +: IW]),
      .func  (cfg[e*GW+2*IW +: FN_W]),
      .y     (nodes[(WIN_TAPS+e)*W +: W])
    );
  end

  assign out_sel = cfg[N_ELEM*GW +: IW];

  always_comb begin
    y = nodes[W-1:0];
    if (int'(out_sel) < NODES) y = nodes[out_sel*W +: W];
  end
endmodule

// File: rtl/fe_scan.sv
module fe_scan #(
  parameter int K  = 128,
  localparam int CW = $clog2(K)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic interior,
  output logic last_int
);
  logic [CW-1:0] col, row;
  logic col_in, row_in;

  assign col_in   = (col != '0) && (col != CW'(K-1));
  assign row_in   = (row != '0) && (row != CW'(K-1));
  assign interior = col_in && row_in;
  assign last_int = (col == CW'(K-2)) && (row == CW'(K-2));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (col == CW'(K-1)) begin
        col <= '0;
        row <= (row == CW'(K-1)) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fe_sad_acc.sv
module fe_sad_acc #(
  parameter int W     = 8,
  parameter int ACC_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_vld,
  input  logic             in_int,
  input  logic             in_last,
  input  logic [W-1:0]     filt,
  input  logic [W-1:0]     refp,
  output logic [ACC_W-1:0] total,
  output logic             fin
);
  logic [W-1:0] filt_q, ref_q;
  logic         vld_q, int_q, last_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q  <= 1'b0;
      int_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      vld_q  <= in_vld;
      int_q  <= in_int;
      last_q <= in_last;
    end
  end

  always_ff @(posedge clk) begin
    filt_q <= filt;
    ref_q  <= refp;
  end

  assign diff = (filt_q > ref_q) ? (filt_q - ref_q) : (ref_q - filt_q);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      total <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= vld_q && last_q;
      if (vld_q && int_q) total <= total + ACC_W'(diff);
    end
  end
endmodule

// File: rtl/evo_filter_fitness.sv
module evo_filter_fitness
  import fe_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int K      = 128,
  parameter int N_ELEM = 8,
  localparam int IW    = $clog2(WIN_TAPS + N_ELEM),
  localparam int GW    = 2*IW + FN_W,
  localparam int CFG_W = N_ELEM*GW + IW,
  localparam int MAXSUM = (K-2)*(K-2)*((1 << PIX_W) - 1),
  localparam int ACC_W = $clog2(MAXSUM + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      in_valid,
  input  logic [WIN_TAPS*PIX_W-1:0] win_pix,
  input  logic [PIX_W-1:0]          ref_pix,
  input  logic [CFG_W-1:0]          cfg_genes,
  output logic [ACC_W-1:0]          fitness,
  output logic                      done
);
  logic accept;
  logic pos_int, pos_last;
  logic [WIN_TAPS*PIX_W-1:0] win_q;
  logic [PIX_W-1:0]          ref_q;
  logic                      v1, int1, last1;
  logic [PIX_W-1:0]          filt;

  assign accept = in_valid && !start;

  fe_scan #(.K(K)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .adv      (accept),
    .interior (pos_int),
    .last_int (pos_last)
  );

  // stage 1: capture the window with its position tags
  always_ff @(posedge clk) begin
    if (rst || start) begin
      v1    <= 1'b0;
      int1  <= 1'b0;
      last1 <= 1'b0;
    end else begin
      v1    <= accept;
      int1  <= pos_int;
      last1 <= pos_last;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      win_q <= win_pix;
      ref_q <= ref_pix;
    end
  end

  fe_array #(.W(PIX_W), .N_ELEM(N_ELEM), .IW(IW)) u_array (
    .win (win_q),
    .cfg (cfg_genes),
    .y   (filt)
  );

  fe_sad_acc #(.W(PIX_W), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (start),
    .in_vld  (v1),
    .in_int  (int1),
    .in_last (last1),
    .filt    (filt),
    .refp    (ref_q),
    .total   (fitness),
    .fin     (done)
  );
endmodule

// File: rtl/evo_filter_fitness_chk.sv
module evo_filter_fitness_chk #(
  parameter int PIX_W = 8,
  parameter int ACC_W = 22
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [ACC_W-1:0] fitness
);
  localparam int MAXPIX = (1 << PIX_W) - 1;

  assert_clear_on_start_R8: assert property (@(posedge clk) disable iff (rst)
    start |=> (fitness == '0) && !done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !start |=> fitness >= $past(fitness));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !start |=> (fitness - $past(fitness)) <= ACC_W'(MAXPIX));

  assert_done_not_after_start_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(start));
endmodule

bind evo_filter_fitness evo_filter_fitness_chk #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .done    (done),
  .fitness (fitness)
);

// File: tb/tb_evo_filter_fitness.sv
`timescale 1ns/1ps
module tb_evo_filter_fitness;
  localparam int K     = 8;
  localparam int NE    = 8;
  localparam int IW    = 5;
  localparam int GW    = 13;
  localparam int CFG_W = 109;
  localparam int NODES = 17;
  localparam int ACC_S = $clog2((K-2)*(K-2)*255 + 1);
  localparam int ACC_B = 22;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, start = 1'b0, in_valid = 1'b0;
  logic [71:0] win = '0;
  logic [7:0]  ref_pix = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic [ACC_S-1:0] fitness;
  logic done;

  logic b_start = 1'b0, b_valid = 1'b0;
  logic [CFG_W-1:0] b_cfg = '0;
  logic [ACC_B-1:0] b_fitness;
  logic b_done;

  evo_filter_fitness #(.K(K), .N_ELEM(NE)) dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .win_pix(win), .ref_pix(ref_pix), .cfg_genes(cfg),
    .fitness(fitness), .done(done));

  evo_filter_fitness dut_big (
    .clk(clk), .rst(rst), .start(b_start), .in_valid(b_valid),
    .win_pix({9{8'hFF}}), .ref_pix(8'h00), .cfg_genes(b_cfg),
    .fitness(b_fitness), .done(b_done));

  int checks = 0, fails = 0;
  string cur_req = "R9";
  int done_cnt = 0, b_done_cnt = 0;
  int unsigned seed = 32'h1234_5678;

  function int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  function automatic int model_filt(input logic [CFG_W-1:0] c, input logic [71:0] w);
    int nd[NODES];
    int sa, sb, f, a, b, o;
    for (int i = 0; i < 9; i++) nd[i] = int'(w[i*8 +: 8]);
    for (int e = 0; e < NE; e++) begin
      sa = int'(c[e*GW +: IW]);
      sb = int'(c[e*GW+IW +: IW]);
      f  = int'(c[e*GW+2*IW +: 3]);
      a  = (sa < 9+e) ? nd[sa] : nd[0];
      b  = (sb < 9+e) ? nd[sb] : nd[0];
      case (f)
        0: nd[9+e] = a | b;
        1: nd[9+e] = a & b;
        2: nd[9+e] = a ^ b;
        3: nd[9+e] = (a + b) % 256;
        4: nd[9+e] = (a + b > 255) ? 255 : a + b;
        5: nd[9+e] = (a + b) / 2;
        6: nd[9+e] = (a > b) ? a : b;
        default: nd[9+e] = (a < b) ? a : b;
      endcase
    end
    o = int'(c[NE*GW +: IW]);
    return (o < NODES) ? nd[o] : nd[0];
  endfunction

  function automatic logic [CFG_W-1:0] set_gene(input logic [CFG_W-1:0] c,
      input int e, input int sa, input int sb, input int f);
    logic [CFG_W-1:0] r;
    r = c;
    r[e*GW +: IW]      = IW'(sa);
    r[e*GW+IW +: IW]   = IW'(sb);
    r[e*GW+2*IW +: 3]  = 3'(f);
    return r;
  endfunction

  function automatic logic [CFG_W-1:0] set_out(input logic [CFG_W-1:0] c, input int o);
    logic [CFG_W-1:0] r;
    r = c;
    r[NE*GW +: IW] = IW'(o);
    return r;
  endfunction

  // behavioural reference: a two-deep queue of pending contributions
  int  exp_acc = 0;
  bit  exp_done = 1'b0;
  bit  pv[2] = '{0, 0};
  bit  pl[2] = '{0, 0};
  int  pd[2] = '{0, 0};
  int  mrow = 0, mcol = 0;

  always @(posedge clk) begin
    if (rst || start) begin
      exp_acc = 0; exp_done = 1'b0;
      pv[0] = 1'b0; pv[1] = 1'b0;
      mrow = 0; mcol = 0;
    end else begin
      exp_done = pv[1] && pl[1];
      if (pv[1]) exp_acc += pd[1];
      pv[1] = pv[0]; pl[1] = pl[0]; pd[1] = pd[0];
      pv[0] = 1'b0;
      if (in_valid) begin
        int fv, d;
        bit inner;
        inner = (mrow >= 1) && (mrow <= K-2) && (mcol >= 1) && (mcol <= K-2);
        fv = model_filt(cfg, win);
        d  = (fv > int'(ref_pix)) ? fv - int'(ref_pix) : int'(ref_pix) - fv;
        pv[0] = 1'b1;
        pd[0] = inner ? d : 0;
        pl[0] = (mrow == K-2) && (mcol == K-2);
        if (mcol == K-1) begin
          mcol = 0;
          mrow = (mrow == K-1) ? 0 : mrow + 1;
        end else mcol++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(fitness) != exp_acc) begin
        fails++;
        $display("FAIL %s fitness got %0d expected %0d at %0t", cur_req, fitness, exp_acc, $time);
      end
      checks++;
      if (done != exp_done) begin
        fails++;
        $display("FAIL %s/R7 done got %0b expected %0b at %0t", cur_req, done, exp_done, $time);
      end
      if (done) done_cnt++;
      if (b_done) b_done_cnt++;
    end
  end

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    done_cnt = 0;
  endtask

  task automatic frame(input bit use_fixed, input logic [71:0] fwin,
      input int fref, input bit gaps);
    int n;
    n = 0;
    while (n < K*K) begin
      @(negedge clk);
      if (gaps && (rnd() % 4 == 0)) begin
        in_valid = 1'b0;
        for (int i = 0; i < 9; i++) win[i*8 +: 8] = 8'(rnd());
      end else begin
        in_valid = 1'b1;
        if (use_fixed) win = fwin;
        else for (int i = 0; i < 9; i++) win[i*8 +: 8] = 8'(rnd());
        ref_pix = (fref >= 0) ? 8'(fref) : 8'(rnd());
        n++;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // directed window: pixel1 = 90, pixel4 = 195, the rest 0
  localparam logic [71:0] WIN_A = {8'd0, 8'd0, 8'd0, 8'd0, 8'd195, 8'd0, 8'd0, 8'd90, 8'd0};
  // pixel0 = 5, pixel1 = 0x50, the rest 0
  localparam logic [71:0] WIN_B = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'h50, 8'd5};

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int exp_fn[8];
    exp_fn = '{119, 34, 53, 71, 155, 42, 95, 10};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_val("R9 reset fitness", int'(fitness), 0);
    check_val("R9 reset done", int'(done), 0);

    // R1 R2: every function on px4=195, px1=90, ref 100
    for (int f = 0; f < 8; f++) begin
      cur_req = (f == 3 || f == 4 || f == 5) ? "R2" : "R1";
      cfg = set_out(set_gene('0, 0, 4, 1, f), 9);
      pulse_start();
      frame(1'b1, WIN_A, 100, 1'b0);
      check_val($sformatf("%s func %0d total", cur_req, f), int'(fitness), exp_fn[f]*(K-2)*(K-2));
      check_val("R7 one done per frame", done_cnt, 1);
    end

    // R3: operands at or above the element's own number read pixel 0
    cur_req = "R3";
    cfg = set_gene('0, 0, 9, 1, 0);
    cfg = set_gene(cfg, 1, 10, 9, 3);
    cfg = set_out(cfg, 10);
    pulse_start();
    frame(1'b1, WIN_B, 0, 1'b0);
    check_val("R3 self operand fallback", int'(fitness), 90*(K-2)*(K-2));

    // R4: output gene beyond the last node picks pixel 0
    cur_req = "R4";
    cfg = set_out(set_gene('0, 0, 1, 1, 3), 31);
    pulse_start();
    frame(1'b1, WIN_B, 0, 1'b0);
    check_val("R4 out of range output gene", int'(fitness), 5*(K-2)*(K-2));

    // R5 R10: random configurations and pixels, gaps in in_valid
    cur_req = "R5 R10";
    for (int r = 0; r < 5; r++) begin
      for (int w = 0; w < 4; w++) cfg[w*32 +: 32] = rnd() ^ (rnd() << 16);
      pulse_start();
      frame(1'b0, '0, -1, 1'b1);
      check_val("R5 random frame total matches model", int'(fitness), exp_acc);
      check_val("R7 one done per random frame", done_cnt, 1);
    end

    // R10: idle cycles do not change the total
    cur_req = "R10";
    begin
      int held;
      held = int'(fitness);
      in_valid = 1'b0;
      repeat (6) begin
        @(negedge clk);
        for (int i = 0; i < 9; i++) win[i*8 +: 8] = 8'(rnd());
      end
      check_val("R10 total held while idle", int'(fitness), held);
    end

    // R8: start in mid-frame with a beat offered in the same cycle
    cur_req = "R8";
    pulse_start();
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); in_valid = 1'b1; ref_pix = 8'(rnd());
      for (int i = 0; i < 9; i++) win[i*8 +: 8] = 8'(rnd());
    end
    start = 1'b1;
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
    check_val("R8 total cleared by start", int'(fitness), 0);
    done_cnt = 0;
    frame(1'b0, '0, -1, 1'b0);
    check_val("R8 fresh frame after restart", int'(fitness), exp_acc);
    check_val("R8 single done after restart", done_cnt, 1);

    // R6: full-size worst-case frame on the default geometry
    cur_req = "R6";
    b_cfg = set_out('0, 4);
    @(negedge clk); b_start = 1'b1;
    @(negedge clk); b_start = 1'b0; b_done_cnt = 0; b_valid = 1'b1;
    repeat (128*128) @(negedge clk);
    b_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_val("R6 worst-case total", int'(b_fitness), 126*126*255);
    check_val("R7 worst-case frame done count", b_done_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule